// File: doc/BRIEF.md
# Standby Mode Power Controller

This block decides when a small processor core sleeps and what wakes it. Software writes an 8-bit control register. One field requests a light sleep, called HALT, in which the core clock is gated and the oscillator keeps running. Another field requests a deep sleep, called STOP, in which the oscillator may also be shut down and output pads may be floated. A deep-sleep request only takes effect if a separate arm strobe has prepared it beforehand, so a stray write cannot put the chip into STOP.

The two sleep modes answer to different wake events. HALT ends on an interrupt, on the external reset pin or on a watchdog reset. STOP ends only on an interrupt or on the external reset pin. When an interrupt ends STOP, the block holds the core clock off for a selectable settling interval before it hands the clock back.

The block drives a core clock enable, an oscillator enable and a pad float control, and it reports its current mode. A register read returns the live register contents at any time.

Top module: `stby_power_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, and after any accepted reset cause, `rd_data` reads 0x08 and `mode` is RUN. The mode encoding is RUN=0, HALT=1, STOP=2, WAIT=3. The register layout is: bit0 stop request, bit1 halt request, bit2 pad float, bit3 oscillator off in STOP, bits 5:4 settling code, bits 7:6 always 0.
- R2: A write in RUN with bit0 set enters STOP on the next cycle only if `stop_arm` was pulsed in RUN after the previous register write. Without that arm, bit0 reads back 0 and the mode stays RUN.
- R3: Every register write consumes the arm. A write that does not enter STOP therefore leaves the block unarmed, and a later STOP request needs a new `stop_arm` pulse.
- R4: A write in RUN with bit1 set enters HALT. An `irq` in HALT returns the mode to RUN on the next cycle with bit1 reading 0 and the other fields unchanged.
- R5: Which reset causes are accepted depends on the mode. RUN accepts all four. HALT accepts only `rst_pin` and `rst_wdt`. STOP and WAIT accept only `rst_pin`. A cause that is not accepted has no effect on the mode or on the register.
- R6: `cpu_clk_en` is 1 only in RUN. `osc_en` is 0 only in STOP with bit3 set. `pad_float` is 1 only in STOP with bit2 set. An `irq` still ends STOP while the pads are floated.
- R7: An `irq` in STOP clears bit0 and enters WAIT. WAIT lasts 2^SH0, 2^SH1 or 2^SH2 cycles for settling codes 0, 1 and 2, and the block then returns to RUN. With code 3 and bit3 clear, the block goes straight from STOP to RUN.
- R8: Settling code 3 together with bit3 set is a reserved combination. A STOP request written with that combination does not enter STOP and consumes the arm, but the fields are still stored.
- R9: Writes to bits 7:6 are ignored, and those bits always read 0.
- R10: Register writes and `stop_arm` have effect only in RUN. An `irq` in RUN or in WAIT has no effect.
- R11: A write that sets both bit0 and bit1 and is accepted as a STOP request enters STOP with bit1 reading 0. If the STOP request is refused, bit1 enters HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin event, one-cycle pulse |
| rst_brk | input | 1 | Break instruction reset event |
| rst_wdt | input | 1 | Watchdog overflow reset event |
| rst_trap | input | 1 | Opcode trap reset event |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| stop_arm | input | 1 | Arms the next STOP request |
| irq | input | 1 | Interrupt request |
| rd_data | output | 8 | Control register read value |
| mode | output | 2 | Current mode: 0 RUN, 1 HALT, 2 STOP, 3 WAIT |
| cpu_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Main oscillator enable |
| pad_float | output | 1 | Float the output pads |

## Verification
The bench sends a STOP request without an arm, and also after the arm has been used up by an unrelated write. A design that keeps the arm alive too long would fall into STOP here. It checks the length of WAIT for every settling code and the direct return for code 3. An off-by-one counter would show up as a wrong cycle for `cpu_clk_en`, and a wrong lookup as a wrong WAIT length. It fires break, trap and watchdog events in STOP and in HALT. A design that ignored the per-mode wake rules would either wake the core too early or fail to wake it. It also writes the reserved oscillator and settling combination and a request with both sleep bits set, to catch a design that gives the two requests the wrong priority.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int REG_W = 8;
    localparam int MODE_W = 2;
    localparam int OST_W = 2;
    localparam logic [REG_W-1:0] CFG_RESET = 8'h08;
    localparam logic [OST_W-1:0] OST_NOWAIT = 2'b11;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN  = 2'd0,
        MODE_HALT = 2'd1,
        MODE_STOP = 2'd2,
        MODE_WAIT = 2'd3
    } stby_mode_e;

    typedef struct packed {
        logic [OST_W-1:0] ost;
        logic             osc_off;
        logic             flt;
        logic             hlt;
        logic             stp;
    } stby_cfg_t;

    localparam int CFG_W = $bits(stby_cfg_t);

    function automatic logic cfg_reserved(input logic osc_off, input logic [OST_W-1:0] ost);
        return osc_off && (ost == OST_NOWAIT);
    endfunction

endpackage

// File: rtl/stby_cfg_reg.sv
module stby_cfg_reg
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             arm,
    input  logic             clr_stp,
    input  logic             clr_hlt,
    output stby_cfg_t        cfg,
    output logic             armed,
    output logic             stop_take,
    output logic             halt_take
);

    typedef struct packed {
        stby_cfg_t cfg;
        logic      armed;
    } reg_st_t;

    reg_st_t st_d, st_q;
    stby_cfg_t wr_cfg;

    assign wr_cfg = stby_cfg_t'(wr_data[CFG_W-1:0]);

    always_comb begin
        stop_take = wr_en && wr_cfg.stp && st_q.armed
                    && !cfg_reserved(wr_cfg.osc_off, wr_cfg.ost);
        halt_take = wr_en && wr_cfg.hlt && !stop_take;

        st_d = st_q;
        if (soft_rst) begin
            st_d.cfg   = stby_cfg_t'(CFG_RESET[CFG_W-1:0]);
            st_d.armed = 1'b0;
        end else begin
            if (wr_en) begin
                st_d.cfg.ost     = wr_cfg.ost;
                st_d.cfg.osc_off = wr_cfg.osc_off;
                st_d.cfg.flt     = wr_cfg.flt;
                st_d.cfg.stp     = stop_take;
                st_d.cfg.hlt     = halt_take;
            end
            if (clr_stp) st_d.cfg.stp = 1'b0;
            if (clr_hlt) st_d.cfg.hlt = 1'b0;
            if (arm)
                st_d.armed = 1'b1;
            else if (wr_en)
                st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= stby_cfg_t'(CFG_RESET[CFG_W-1:0]);
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg   = st_q.cfg;
    assign armed = st_q.armed;

endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer
    import stby_pkg::*;
#(
    parameter int SH0 = 8,
    parameter int SH1 = 12,
    parameter int SH2 = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic [OST_W-1:0] code,
    output logic             zero_len,
    output logic             done
);

    localparam int CNT_W = SH2 + 1;
    localparam int NCODES = 3;
    localparam int SHIFT_TAB [NCODES] = '{SH0, SH1, SH2};

    logic [CNT_W-1:0] len_tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_len
        assign len_tab[g] = CNT_W'(1) << SHIFT_TAB[g];
    end

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [CNT_W-1:0] load_len;

    always_comb begin
        zero_len = (code == OST_NOWAIT);
        load_len = zero_len ? '0 : len_tab[code];

        st_d = st_q;
        if (clear) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (start && !zero_len) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_len - CNT_W'(1);
        end else if (st_q.busy) begin
            if (st_q.cnt == '0)
                st_d.busy = 1'b0;
            else
                st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        done = st_q.busy && (st_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_pin,
    input  logic       rst_brk,
    input  logic       rst_wdt,
    input  logic       rst_trap,
    input  logic       irq,
    input  logic       stop_take,
    input  logic       halt_take,
    input  logic       stab_zero,
    input  logic       stab_done,
    output stby_mode_e mode,
    output logic       soft_rst,
    output logic       wake_stop,
    output logic       wake_halt,
    output logic       in_run
);

    typedef struct packed {
        stby_mode_e mode;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        unique case (st_q.mode)
            MODE_RUN:  soft_rst = rst_pin || rst_brk || rst_wdt || rst_trap;
            MODE_HALT: soft_rst = rst_pin || rst_wdt;
            default:   soft_rst = rst_pin;
        endcase

        in_run    = (st_q.mode == MODE_RUN);
        wake_stop = (st_q.mode == MODE_STOP) && irq && !soft_rst;
        wake_halt = (st_q.mode == MODE_HALT) && irq && !soft_rst;

        st_d = st_q;
        if (soft_rst) begin
            st_d.mode = MODE_RUN;
        end else begin
            unique case (st_q.mode)
                MODE_RUN: begin
                    if (stop_take)
                        st_d.mode = MODE_STOP;
                    else if (halt_take)
                        st_d.mode = MODE_HALT;
                end
                MODE_HALT: begin
                    if (wake_halt) st_d.mode = MODE_RUN;
                end
                MODE_STOP: begin
                    if (wake_stop) st_d.mode = stab_zero ? MODE_RUN : MODE_WAIT;
                end
                MODE_WAIT: begin
                    if (stab_done) st_d.mode = MODE_RUN;
                end
                default: st_d.mode = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.mode <= MODE_RUN;
        else
            st_q <= st_d;
    end

    assign mode = st_q.mode;

endmodule

// File: rtl/stby_power_ctrl.sv
module stby_power_ctrl
    import stby_pkg::*;
#(
    parameter int SH0 = 8,
    parameter int SH1 = 12,
    parameter int SH2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin,
    input  logic              rst_brk,
    input  logic              rst_wdt,
    input  logic              rst_trap,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic              stop_arm,
    input  logic              irq,
    output logic [REG_W-1:0]  rd_data,
    output logic [MODE_W-1:0] mode,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              pad_float
);

    stby_mode_e cur_mode;
    stby_cfg_t  cfg;
    logic soft_rst, wake_stop, wake_halt, in_run;
    logic stop_take, halt_take, stop_armed;
    logic stab_zero, stab_done;
    logic wr_gated, arm_gated;

    assign wr_gated  = reg_wr_en && in_run;
    assign arm_gated = stop_arm && in_run;

    stby_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_en     (wr_gated),
        .wr_data   (reg_wr_data),
        .arm       (arm_gated),
        .clr_stp   (wake_stop),
        .clr_hlt   (wake_halt),
        .cfg       (cfg),
        .armed     (stop_armed),
        .stop_take (stop_take),
        .halt_take (halt_take)
    );

    stby_stab_timer #(
        .SH0 (SH0),
        .SH1 (SH1),
        .SH2 (SH2)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (soft_rst),
        .start    (wake_stop),
        .code     (cfg.ost),
        .zero_len (stab_zero),
        .done     (stab_done)
    );

    stby_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_pin   (rst_pin),
        .rst_brk   (rst_brk),
        .rst_wdt   (rst_wdt),
        .rst_trap  (rst_trap),
        .irq       (irq),
        .stop_take (stop_take),
        .halt_take (halt_take),
        .stab_zero (stab_zero),
        .stab_done (stab_done),
        .mode      (cur_mode),
        .soft_rst  (soft_rst),
        .wake_stop (wake_stop),
        .wake_halt (wake_halt),
        .in_run    (in_run)
    );

    assign rd_data    = {{(REG_W-CFG_W){1'b0}}, cfg};
    assign mode       = cur_mode;
    assign cpu_clk_en = in_run;
    assign osc_en     = !((cur_mode == MODE_STOP) && cfg.osc_off);
    assign pad_float  = (cur_mode == MODE_STOP) && cfg.flt;

endmodule

// File: rtl/stby_power_ctrl_chk.sv
module stby_power_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_pin,
    input logic       reg_wr_en,
    input logic [7:0] reg_wr_data,
    input logic       irq,
    input logic [7:0] rd_data,
    input logic [1:0] mode,
    input logic       osc_en,
    input logic       stop_armed
);

    a_r2_stop_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && mode == 2'd0 && !stop_armed) |=> mode != 2'd2);

    a_r8_reserved_combo: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && mode == 2'd0 && reg_wr_data[3] && reg_wr_data[5:4] == 2'b11)
        |=> mode != 2'd2);

    a_r4_halt_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && irq) |=> mode == 2'd0);

    a_r7_stop_irq_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && irq) |=> (mode == 2'd3 || mode == 2'd0));

    a_r1_pin_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin |=> (mode == 2'd0 && rd_data == 8'h08));

    a_r9_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00);

    a_r6_osc_outside_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2) |-> osc_en);

    a_r10_wait_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && reg_wr_en && !rst_pin) |=> $stable(rd_data[5:2]));

endmodule

bind stby_power_ctrl stby_power_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pin     (rst_pin),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .irq         (irq),
    .rd_data     (rd_data),
    .mode        (mode),
    .osc_en      (osc_en),
    .stop_armed  (stop_armed)
);

// File: tb/stby_power_ctrl_bench.sv
module stby_power_ctrl_bench;

    localparam int SH0 = 2;
    localparam int SH1 = 3;
    localparam int SH2 = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 0, rst_brk = 0, rst_wdt = 0, rst_trap = 0;
    logic reg_wr_en = 0;
    logic [7:0] reg_wr_data = 8'h00;
    logic stop_arm = 0, irq = 0;
    logic [7:0] rd_data;
    logic [1:0] mode;
    logic cpu_clk_en, osc_en, pad_float;

    always #4 clk = ~clk;

    stby_power_ctrl #(.SH0(SH0), .SH1(SH1), .SH2(SH2)) u_stby_power_ctrl (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .rst_brk(rst_brk),
        .rst_wdt(rst_wdt), .rst_trap(rst_trap), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .stop_arm(stop_arm), .irq(irq),
        .rd_data(rd_data), .mode(mode), .cpu_clk_en(cpu_clk_en),
        .osc_en(osc_en), .pad_float(pad_float)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference model
    int m_mode = 0;
    logic [7:0] m_reg = 8'h08;
    bit m_armed = 0;
    int m_wait = 0;

    function automatic int wait_len(input logic [1:0] code);
        case (code)
            2'd0: return 1 << SH0;
            2'd1: return 1 << SH1;
            2'd2: return 1 << SH2;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit accept;
        bit stp_ok, hlt_ok;
        if (!rst_n) begin
            m_mode = 0; m_reg = 8'h08; m_armed = 0; m_wait = 0;
        end else begin
            if (m_mode == 0) accept = rst_pin | rst_brk | rst_wdt | rst_trap;
            else if (m_mode == 1) accept = rst_pin | rst_wdt;
            else accept = rst_pin;
            if (accept) begin
                m_mode = 0; m_reg = 8'h08; m_armed = 0; m_wait = 0;
            end else if (m_mode == 0) begin
                if (reg_wr_en) begin
                    stp_ok = reg_wr_data[0] && m_armed
                             && !(reg_wr_data[3] && reg_wr_data[5:4] == 2'b11);
                    hlt_ok = reg_wr_data[1] && !stp_ok;
                    m_reg = (reg_wr_data & 8'h3C) | {6'd0, hlt_ok, stp_ok};
                    if (stp_ok) m_mode = 2;
                    else if (hlt_ok) m_mode = 1;
                end
                if (stop_arm) m_armed = 1;
                else if (reg_wr_en) m_armed = 0;
            end else if (m_mode == 1) begin
                if (irq) begin m_reg[1] = 1'b0; m_mode = 0; end
            end else if (m_mode == 2) begin
                if (irq) begin
                    m_reg[0] = 1'b0;
                    m_wait = wait_len(m_reg[5:4]);
                    m_mode = (m_wait == 0) ? 0 : 3;
                end
            end else begin
                m_wait = m_wait - 1;
                if (m_wait == 0) m_mode = 0;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("mode", int'(mode), m_mode);
        chk("rd_data", int'(rd_data), int'(m_reg));
        chk("cpu_clk_en", int'(cpu_clk_en), int'(m_mode == 0));
        chk("osc_en", int'(osc_en), int'(!(m_mode == 2 && m_reg[3])));
        chk("pad_float", int'(pad_float), int'(m_mode == 2 && m_reg[2]));
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
        reg_wr_en = 0; stop_arm = 0; irq = 0;
        rst_pin = 0; rst_brk = 0; rst_wdt = 0; rst_trap = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr_en = 1; reg_wr_data = d; tick();
    endtask

    task automatic arm();
        stop_arm = 1; tick();
    endtask

    task automatic pulse_irq();
        irq = 1; tick();
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL %s watchdog expired actual=hung expected=done", tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tag = "R1"; idle(2);
        rst_n = 1; idle(2);
        chk("reset readback R1", int'(rd_data), 8'h08);

        tag = "R9"; wr(8'hC4); idle(1);
        chk("reserved bits R9", int'(rd_data), 8'h04);

        tag = "R2"; wr(8'h01); idle(2);
        chk("unarmed stop R2", int'(mode), 0);

        tag = "R3"; arm(); wr(8'h04); wr(8'h09); idle(2);
        chk("arm consumed R3", int'(mode), 0);

        tag = "R6"; arm(); wr(8'h0D); idle(3);
        chk("float in stop R6", int'(pad_float), 1);
        tag = "R7"; pulse_irq(); idle(8);
        chk("back to run code0 R7", int'(cpu_clk_en), 1);

        tag = "R5"; arm(); wr(8'h11);
        rst_wdt = 1; tick(); rst_brk = 1; tick(); rst_trap = 1; tick();
        chk("stop ignores causes R5", int'(mode), 2);
        tag = "R7"; pulse_irq(); idle(12);

        arm(); wr(8'h21); idle(1); pulse_irq(); idle(20);
        chk("code2 done R7", int'(mode), 0);

        arm(); wr(8'h31); idle(1); pulse_irq();
        chk("code3 direct R7", int'(mode), 0);

        tag = "R8"; arm(); wr(8'h39); idle(1);
        chk("reserved combo R8", int'(rd_data), 8'h38);
        wr(8'h01); idle(1);
        chk("reserved consumed arm R8", int'(mode), 0);

        tag = "R4"; wr(8'h02); rst_brk = 1; tick(); rst_trap = 1; tick();
        chk("halt ignores brk R4", int'(mode), 1);
        pulse_irq(); idle(1);
        chk("halt irq wake R4", int'(rd_data), 8'h00);
        tag = "R5"; wr(8'h06); rst_wdt = 1; tick();
        chk("halt wdt wake R5", int'(rd_data), 8'h08);
        wr(8'h02); rst_pin = 1; tick();

        tag = "R11"; arm(); wr(8'h0B); idle(1);
        chk("both bits stop wins R11", int'(rd_data), 8'h09);
        pulse_irq(); idle(6);
        arm(); wr(8'h3B); idle(1);
        chk("refused stop goes halt R11", int'(mode), 1);
        pulse_irq();

        tag = "R10"; wr(8'h08); pulse_irq(); arm(); wr(8'h05);
        pulse_irq(); wr(8'h30); stop_arm = 1; tick(); idle(6);
        chk("write in wait ignored R10", int'(rd_data), 8'h04);
        wr(8'h02); wr(8'h00); arm(); pulse_irq(); idle(1);
        chk("write in halt ignored R10", int'(rd_data), 8'h00);
        wr(8'h01); idle(1);
        chk("arm in halt ignored R10", int'(mode), 0);

        tag = "R1"; arm(); wr(8'h01); idle(1); rst_pin = 1; tick();
        chk("pin ends stop R1", int'(mode), 0);
        wr(8'h34); rst_trap = 1; tick();
        chk("trap in run R1", int'(rd_data), 8'h08);
        wr(8'h34); idle(1);
        rst_n = 0; #1;
        chk("async reset R1", int'(rd_data), 8'h08);
        idle(1); rst_n = 1; idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule